// File: doc/BRIEF.md
# Byte-In, Word-Out Receive FIFO with Fill Status

This block buffers the receive data of a serial flash controller. The deserializer hands it one byte per cycle with a valid strobe. Software takes the data out as 32-bit words through a read strobe. Each read removes up to four bytes. The oldest byte lands in the lowest byte lane.

A 12-bit status word reports the fill level continuously. It carries an empty flag, a non-empty ready flag, the byte count, and three fill flags at 16, 32 and 64 bytes. A clear strobe flushes the FIFO. A read issued while the FIFO is empty raises a sticky underrun flag. That flag stays set until the next clear.

The FIFO depth is a parameter. The count saturates at the depth: a byte that arrives while the FIFO is full is lost.

Top module: `rxq_word_fifo`

## Requirements
- R1: After reset the count is zero, empty is set, ready and all fill flags are clear, underrun is clear and the read word is zero.
- R2: A byte presented with `in_valid` high, with no clear in the same cycle, raises the count by one, visible in the status word the cycle after the edge.
- R3: A read with four or more bytes stored removes four bytes. The read word, visible after the edge, holds the oldest byte in bits 7:0, the next in 15:8, then 23:16, then 31:24.
- R4: A read with one to three bytes stored removes all of them. They are packed into the lowest lanes in arrival order, and the unfilled upper lanes read as zero.
- R5: The status word layout is fixed:
  - bit 0 is ready (count at least 1);
  - bit 1 is set when the count is at least 16;
  - bit 2 is set when the count is at least 32;
  - bit 3 is set when the count is at least 64;
  - bits 10:4 hold the byte count;
  - bit 11 is empty (count zero).
- R6: While the count equals DEPTH, incoming bytes are dropped and the count stays at DEPTH. The stored bytes keep their order.
- R7: A clear empties the FIFO and resets underrun. A byte arriving in the same cycle is discarded. A read in the same cycle has no effect: the read word keeps its previous value.
- R8: A read while empty sets the underrun flag, loads a zero read word and leaves the count at zero. The flag stays set until a clear.
- R9: A read and an incoming byte in the same cycle both take effect. The read takes bytes from the contents before the edge, and the new byte is appended after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming byte strobe |
| in_byte | input | 8 | Incoming byte |
| rd_req | input | 1 | Word read strobe |
| clr_req | input | 1 | FIFO flush strobe |
| rd_word | output | 32 | Last word read, oldest byte in bits 7:0 |
| status | output | 12 | Fill status word (layout in R5) |
| underrun | output | 1 | Sticky read-while-empty flag |

## Verification
A behavioural byte queue in the bench is stepped alongside the design every cycle. The read word, status word and underrun flag are compared against it after each edge.

The stimulus covers these patterns:
- Word reads that drain whole words, which separate correct lane order from reversed order.
- Reads of one and three leftover bytes, which expose stale or unmasked upper lanes.
- A fill past the depth, which shows whether the count saturates and whether the dropped bytes disturb the stored order.
- A read while empty, checked before and after a clear.
- Push-with-read cycles and a clear that coincides with a push and a read, which tell apart the priority among the three strobes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int LEVEL_W = 7;
    localparam int LANES   = 4;

    // Status word; packed MSB first so that bit 0 is ready, bit 11 is empty.
    typedef struct packed {
        logic               empty;
        logic [LEVEL_W-1:0] level;
        logic               ge64;
        logic               ge32;
        logic               ge16;
        logic               ready;
    } rxq_status_t;

    function automatic logic [LEVEL_W-1:0] clip_level(input int unsigned n);
        return (n > 127) ? 7'd127 : LEVEL_W'(n);
    endfunction

    function automatic logic [2:0] take_count(input int unsigned n);
        return (n >= LANES) ? 3'd4 : 3'(n);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   push_req,
    input  logic [7:0]             push_byte,
    input  logic                   pop_req,
    output logic [CW-1:0]          count,
    output logic [LANES-1:0][7:0]  peek
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;
    logic          push_ok;
    logic [2:0]    pop_n;

    function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p, input int unsigned k);
        int unsigned s;
        s = 32'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return AW'(s);
    endfunction

    assign push_ok = push_req && !clr && (32'(count_q) < DEPTH);
    assign pop_n   = (pop_req && !clr) ? take_count(32'(count_q)) : 3'd0;
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[tail_q] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) tail_q <= wrap_add(tail_q, 1);
            head_q  <= wrap_add(head_q, 32'(pop_n));
            count_q <= count_q - CW'(pop_n) + CW'(push_ok);
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign peek[i] = (32'(count_q) > i) ? mem[wrap_add(head_q, i)] : 8'h00;
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        32'(count_q) <= DEPTH);

    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (32'(count_q) == DEPTH && !pop_req && !clr) |=> (32'(count_q) == DEPTH));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0));

    a_r3_word_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !clr && 32'(count_q) >= 4)
            |=> (32'(count_q) == 32'($past(count_q)) - 4));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic [CW-1:0] count,
    output rxq_status_t   stat
);

    int unsigned n;
    assign n = 32'(count);

    always_comb begin
        stat.ready = (n >= 1);
        stat.ge16  = (n >= 16);
        stat.ge32  = (n >= 32);
        stat.ge64  = (n >= 64);
        stat.level = clip_level(n);
        stat.empty = (n == 0);
    end

endmodule

// File: rtl/rxq_word_fifo.sv
module rxq_word_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        rd_req,
    input  logic        clr_req,
    output logic [31:0] rd_word,
    output logic [11:0] status,
    output logic        underrun
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]         count;
    logic [LANES-1:0][7:0] peek;
    rxq_status_t           stat;
    logic [31:0]           word_q;
    logic                  under_q;

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_req),
        .push_req (in_valid),
        .push_byte(in_byte),
        .pop_req  (rd_req),
        .count    (count),
        .peek     (peek)
    );

    rxq_status #(.CW(CW)) status_i (
        .count(count),
        .stat (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            under_q <= 1'b0;
        end else if (clr_req) begin
            under_q <= 1'b0;
        end else if (rd_req) begin
            word_q <= peek;
            if (count == '0) under_q <= 1'b1;
        end
    end

    assign rd_word  = word_q;
    assign status   = stat;
    assign underrun = under_q;

    a_r8_underrun_set: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !clr_req && count == '0) |=> (underrun && rd_word == 32'h0));

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_req) |=> underrun);

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !clr_req && 32'(count) == 1) |=> (rd_word[31:8] == 24'h0));

    a_r7_read_ignored: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> ($stable(rd_word) && !underrun));

endmodule

// File: tb/rxq_word_fifo_tb.sv
module rxq_word_fifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, rd_req, clr_req;
    logic [7:0]  in_byte;
    logic [31:0] rd_word;
    logic [11:0] status;
    logic        underrun;

    int checks = 0;
    int errors = 0;

    logic [7:0]  q[$];
    logic [31:0] m_word;
    logic        m_under;
    logic [7:0]  seq_byte = 8'h10;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_word_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .rd_req(rd_req), .clr_req(clr_req), .rd_word(rd_word),
        .status(status), .underrun(underrun)
    );

    function automatic logic [11:0] exp_status(input int n);
        logic [11:0] s;
        s[0]    = (n >= 1);
        s[1]    = (n >= 16);
        s[2]    = (n >= 32);
        s[3]    = (n >= 64);
        s[10:4] = 7'(n);
        s[11]   = (n == 0);
        return s;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "status", 32'(status), 32'(exp_status(q.size())));
        check(tag, "rd_word", rd_word, m_word);
        check(tag, "underrun", 32'(underrun), 32'(m_under));
    endtask

    // One cycle: drive, clock, update the model, compare.
    task automatic step(input string tag, input logic v, input logic [7:0] b,
                        input logic rd, input logic clr);
        int pre;
        in_valid = v; in_byte = b; rd_req = rd; clr_req = clr;
        @(posedge clk);
        pre = q.size();
        if (clr) begin
            q.delete();
            m_under = 1'b0;
        end else begin
            if (rd) begin
                if (pre == 0) begin
                    m_under = 1'b1;
                    m_word  = 32'h0;
                end else begin
                    m_word = 32'h0;
                    for (int i = 0; i < 4 && i < pre; i++) m_word[8*i +: 8] = q.pop_front();
                end
            end
            if (v && pre < DEPTH) q.push_back(b);
        end
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic push_n(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step(tag, 1'b1, seq_byte, 1'b0, 1'b0);
            seq_byte = seq_byte + 8'd1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_byte = 0; rd_req = 0; clr_req = 0;
        m_word = 0; m_under = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        push_n("R2", 5);
        step("R3", 1'b0, 8'h00, 1'b1, 1'b0);
        step("R4", 1'b0, 8'h00, 1'b1, 1'b0);
        push_n("R2", 3);
        step("R4", 1'b0, 8'h00, 1'b1, 1'b0);

        step("R8", 1'b0, 8'h00, 1'b1, 1'b0);
        step("R8", 1'b0, 8'h00, 1'b0, 1'b0);
        step("R8", 1'b0, 8'h00, 1'b1, 1'b0);
        step("R7", 1'b0, 8'h00, 1'b0, 1'b1);

        push_n("R5", 70);
        step("R6", 1'b1, 8'hEE, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) step("R3", 1'b0, 8'h00, 1'b1, 1'b0);

        push_n("R9", 2);
        for (int i = 0; i < 6; i++) begin
            step("R9", 1'b1, seq_byte, 1'b1, 1'b0);
            seq_byte = seq_byte + 8'd1;
        end
        push_n("R9", 6);
        step("R7", 1'b1, 8'hAB, 1'b1, 1'b1);
        step("R7", 1'b0, 8'h00, 1'b0, 1'b0);
        push_n("R2", 2);
        step("R4", 1'b0, 8'h00, 1'b1, 1'b0);
        step("R8", 1'b0, 8'h00, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule